// File: doc/BRIEF.md
# Trace Byte FIFO with Free-Space Stall Warning

This block buffers trace bytes between a packet generator and a trace output port. Each cycle the generator may offer a packet of one to four bytes. The packet enters the FIFO only if all of its bytes fit. Bytes leave one per cycle through a valid/ready handshake, lowest lane first and in arrival order.

A programmable level sets a free-byte threshold. When the number of free bytes falls below that level, a warning output can hold off the processor. The warning is gated by a stall-enable control bit.

If a packet does not fit, the whole packet is discarded and a sticky overflow flag is raised. The bytes already stored are untouched, so the output stream stays clean once the FIFO drains. The flag clears in two cases: the power-down control bit is set, or trace is restarted (a rising edge of the trace-enable input) while the FIFO is empty. A small write/read port reaches the control bits, the level and the flag.

Top module: `trace_fifo_stall`

## Requirements
- R1: After reset, `out_valid`, `fifo_warn` and `ovf_flag` are 0, the control word reads 0x04 (program bit set, stall-enable and power-down clear) and the level reads 0.
- R2: Stored bytes leave on `out_data` one per cycle in which `out_valid` and `out_ready` are both 1. They leave in arrival order, and within a packet lane 0 (`in_data[7:0]`) goes first. While `out_ready` is 0, a presented byte stays stable. When the FIFO is empty, `out_valid` is 0.
- R3: A packet with `in_valid`=1 and `in_count` from 1 to 4 is stored when `in_count` is no larger than the free bytes (DEPTH minus the stored count, before any pop in that cycle). Otherwise the whole packet is discarded and the stored contents are unchanged.
- R4: A discarded packet sets `ovf_flag` at the next clock edge, unless power-down is set.
- R5: With stall-enable set, `fifo_warn` is 1 exactly when the free bytes are strictly fewer than the level.
- R6: With stall-enable clear, `fifo_warn` stays 0 whatever the fill and the level.
- R7: A rising edge on `trace_en` while the FIFO is empty clears `ovf_flag`. A rising edge while bytes remain stored leaves it set.
- R8: While the power-down bit is 1, `ovf_flag` is cleared and stays 0, even if packets are discarded.
- R9: Writing the program bit, set or clear, does not change `ovf_flag`.
- R10: Register port (write on `cfg_we`, read combinationally):
  - address 0 is the control word: bit 0 power-down, bit 1 stall-enable, bit 2 program.
  - address 1 is the 8-bit level.
  - address 2 reads the flag in bit 0; writes to it are ignored.
- R11: A cycle with `in_valid`=0, or with `in_count`=0, stores nothing and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Trace enable; a rising edge marks a restart |
| in_valid | input | 1 | Packet offered this cycle |
| in_count | input | 3 | Bytes in the packet (0 to 4) |
| in_data | input | 32 | Packet bytes, lane 0 in bits 7:0 |
| out_valid | output | 1 | A byte is presented |
| out_ready | input | 1 | Consumer takes the presented byte |
| out_data | output | 8 | Presented byte |
| fifo_warn | output | 1 | Free space below level, gated by stall-enable |
| ovf_flag | output | 1 | Sticky untraced-overflow flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |

## Verification
The assertions assume `in_count` never exceeds the lane count, and that `trace_en` and the register port change only between clock edges. The head-stability property also assumes the consumer never sees a byte replaced under a stalled handshake. The stimulus changes every input shortly after the falling edge and offers only packets of zero to four bytes. Overflow is provoked only with `out_ready` held low, so the bench knows the exact free space at every push.

// File: rtl/trf_pkg.sv
package trf_pkg;

  typedef enum logic [1:0] {
    CFG_CTRL   = 2'd0,
    CFG_LEVEL  = 2'd1,
    CFG_STATUS = 2'd2
  } cfg_sel_e;

  localparam int CTRL_PWRDN = 0;
  localparam int CTRL_STALL = 1;
  localparam int CTRL_PROG  = 2;
  localparam int CTRL_W     = 3;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 3'b100;

  function automatic int unsigned free_bytes(input int unsigned depth, input int unsigned used);
    return depth - used;
  endfunction

  function automatic logic packet_fits(input int unsigned room, input int unsigned need);
    return need <= room;
  endfunction

  function automatic logic below_level(input int unsigned room, input int unsigned lvl);
    return room < lvl;
  endfunction

endpackage

// File: rtl/trf_store.sv
module trf_store #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [CW-1:0]      push_cnt,
  input  logic [LANES*8-1:0] push_data,
  input  logic               pop,
  output logic [FW-1:0]      fill,
  output logic [7:0]         head
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [7:0]    lane_byte [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_byte[g] = push_data[g*8 +: 8];
    end
  endgenerate

  // Byte i of an accepted packet lands i slots past the write pointer.
  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(push_cnt)) mem[wr_ptr + AW'(i)] <= lane_byte[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(push_cnt);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      fill <= fill + (push ? FW'(push_cnt) : FW'(0)) - FW'(pop);
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/trf_admit.sv
module trf_admit
  import trf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int FW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] fill,
  input  logic          in_valid,
  input  logic [CW-1:0] in_count,
  input  logic [7:0]    level,
  input  logic          stall_en,
  input  logic          trace_en,
  output logic          push_ok,
  output logic          ovf_evt,
  output logic          warn,
  output logic          restart
);

  logic        trace_en_q;
  logic        wants;
  int unsigned room;

  always_comb begin
    room    = free_bytes(DEPTH, 32'(fill));
    wants   = in_valid && (in_count != '0) && (int'(in_count) <= LANES);
    push_ok = wants && packet_fits(room, 32'(in_count));
    ovf_evt = wants && !push_ok;
    warn    = stall_en && below_level(room, 32'(level));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trace_en_q <= 1'b0;
    else        trace_en_q <= trace_en;
  end

  assign restart = trace_en && !trace_en_q;

endmodule

// File: rtl/trf_regs.sv
module trf_regs
  import trf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       ovf_evt,
  input  logic       restart,
  input  logic       empty,
  output logic       pwrdn,
  output logic       stall_en,
  output logic       prog,
  output logic [7:0] level,
  output logic       flag,
  output logic [7:0] cfg_rdata
);

  logic [CTRL_W-1:0] ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RESET;
      level <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_CTRL)  ctrl  <= cfg_wdata[CTRL_W-1:0];
      if (cfg_addr == CFG_LEVEL) level <= cfg_wdata;
    end
  end

  assign pwrdn    = ctrl[CTRL_PWRDN];
  assign stall_en = ctrl[CTRL_STALL];
  assign prog     = ctrl[CTRL_PROG];

  // Power-down wins, a fresh drop wins over a restart, restart clears only when drained.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (pwrdn)            flag <= 1'b0;
    else if (ovf_evt)          flag <= 1'b1;
    else if (restart && empty) flag <= 1'b0;
  end

  always_comb begin
    case (cfg_addr)
      CFG_CTRL:   cfg_rdata = {{(8-CTRL_W){1'b0}}, ctrl};
      CFG_LEVEL:  cfg_rdata = level;
      CFG_STATUS: cfg_rdata = {7'b0, flag};
      default:    cfg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/trace_fifo_stall.sv
module trace_fifo_stall #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int FW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_en,
  input  logic               in_valid,
  input  logic [CW-1:0]      in_count,
  input  logic [LANES*8-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               fifo_warn,
  output logic               ovf_flag,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata
);

  logic [FW-1:0] fill;
  logic          push_ok;
  logic          ovf_evt;
  logic          restart;
  logic          pop;
  logic          pwrdn;
  logic          stall_en;
  logic          prog;
  logic [7:0]    level;

  assign out_valid = (fill != '0);
  assign pop       = out_valid && out_ready;

  trf_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ok),
    .push_cnt  (in_count),
    .push_data (in_data),
    .pop       (pop),
    .fill      (fill),
    .head      (out_data)
  );

  trf_admit #(.DEPTH(DEPTH), .LANES(LANES)) u_admit (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill     (fill),
    .in_valid (in_valid),
    .in_count (in_count),
    .level    (level),
    .stall_en (stall_en),
    .trace_en (trace_en),
    .push_ok  (push_ok),
    .ovf_evt  (ovf_evt),
    .warn     (fifo_warn),
    .restart  (restart)
  );

  trf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ovf_evt   (ovf_evt),
    .restart   (restart),
    .empty     (!out_valid),
    .pwrdn     (pwrdn),
    .stall_en  (stall_en),
    .prog      (prog),
    .level     (level),
    .flag      (ovf_flag),
    .cfg_rdata (cfg_rdata)
  );

endmodule

// File: rtl/trf_checker.sv
module trf_checker #(
  parameter int DEPTH = 32,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic [FW-1:0] fill,
  input logic          stall_en,
  input logic          fifo_warn,
  input logic          ovf_evt,
  input logic          restart,
  input logic          pwrdn,
  input logic          ovf_flag,
  input logic          pop
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  a_r3_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !pop |=> fill == $past(fill));

  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r6_warn_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_en |-> !fifo_warn);

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !pwrdn |=> ovf_flag);

  a_r8_pwrdn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !ovf_flag);

  a_r7_busy_restart_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && restart && out_valid && !pwrdn |=> ovf_flag);

endmodule

bind trace_fifo_stall trf_checker #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fill      (fill),
  .stall_en  (stall_en),
  .fifo_warn (fifo_warn),
  .ovf_evt   (ovf_evt),
  .restart   (restart),
  .pwrdn     (pwrdn),
  .ovf_flag  (ovf_flag),
  .pop       (pop)
);

// File: tb/trace_fifo_stall_tb.sv
`timescale 1ns/1ps
module trace_fifo_stall_tb;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_count = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        fifo_warn;
  logic        ovf_flag;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] sb [$];

  always #2.5 clk = ~clk;

  trace_fifo_stall u_dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .in_valid(in_valid), .in_count(in_count), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_warn(fifo_warn), .ovf_flag(ovf_flag),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Driver: predicts acceptance from the scoreboard depth, which equals the stored count here.
  task automatic push_pkt(input int n, input logic [7:0] base, input bit valid);
    bit fits;
    in_valid = valid;
    in_count = 3'(n);
    for (int i = 0; i < 4; i++) in_data[i*8 +: 8] = (i < n) ? base + 8'(i) : 8'hEE;
    fits = valid && n > 0 && n <= DEPTH - sb.size();
    if (fits) for (int i = 0; i < n; i++) sb.push_back(base + 8'(i));
    tick();
    in_valid = 1'b0;
    in_count = '0;
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #0.5;
    d = cfg_rdata;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int k = 0; k < 200 && sb.size() != 0; k++) tick();
    chk(out_valid == 1'b0, "R2 empty after drain", int'(out_valid), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: checks every handshake just before the edge that completes it.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (out_valid === 1'b1 && out_ready === 1'b1) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected byte", int'(out_data), 0);
        end else begin
          logic [7:0] exp;
          exp = sb.pop_front();
          chk(out_data == exp, "R2 byte order", int'(out_data), int'(exp));
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(fifo_warn == 1'b0, "R1 fifo_warn", int'(fifo_warn), 0);
    chk(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
    cfg_rd(2'd0, rd); chk(rd == 8'h04, "R1 control", int'(rd), 4);
    cfg_rd(2'd1, rd); chk(rd == 8'h00, "R1 level", int'(rd), 0);

    // R2 mixed packet sizes while draining
    out_ready = 1'b1;
    push_pkt(1, 8'h10, 1'b1);
    push_pkt(2, 8'h20, 1'b1);
    push_pkt(3, 8'h30, 1'b1);
    push_pkt(4, 8'h40, 1'b1);
    push_pkt(4, 8'h50, 1'b1);
    drain();

    // R10 register map
    cfg_wr(2'd1, 8'h5A);
    cfg_rd(2'd1, rd); chk(rd == 8'h5A, "R10 level readback", int'(rd), 'h5A);
    cfg_wr(2'd2, 8'hFF);
    cfg_rd(2'd2, rd); chk(rd == 8'h00, "R10 status write ignored", int'(rd), 0);
    cfg_rd(2'd0, rd); chk(rd == 8'h04, "R10 control unchanged", int'(rd), 4);

    // R6 warning gated off
    out_ready = 1'b0;
    cfg_wr(2'd1, 8'hFF);
    push_pkt(4, 8'h60, 1'b1);
    push_pkt(4, 8'h64, 1'b1);
    chk(fifo_warn == 1'b0, "R6 warn low with stall disabled", int'(fifo_warn), 0);

    // R5 threshold, strictly below
    cfg_wr(2'd0, 8'h02);
    cfg_wr(2'd1, 8'd20);
    chk(fifo_warn == 1'b0, "R5 free 24 level 20", int'(fifo_warn), 0);
    push_pkt(4, 8'h68, 1'b1);
    chk(fifo_warn == 1'b0, "R5 free 20 equals level", int'(fifo_warn), 0);
    push_pkt(1, 8'h6C, 1'b1);
    chk(fifo_warn == 1'b1, "R5 free 19 below level", int'(fifo_warn), 1);

    // R3, R4 whole-packet drop and flag
    for (int p = 0; p < 4; p++) push_pkt(4, 8'h70 + 8'(p*4), 1'b1);
    chk(ovf_flag == 1'b0, "R4 no flag while fitting", int'(ovf_flag), 0);
    push_pkt(4, 8'hA0, 1'b1);
    chk(ovf_flag == 1'b1, "R4 flag after drop", int'(ovf_flag), 1);
    cfg_rd(2'd2, rd); chk(rd == 8'h01, "R10 status shows flag", int'(rd), 1);
    push_pkt(3, 8'hB0, 1'b1);
    push_pkt(1, 8'hC0, 1'b1);
    // R11 idle and zero-length offers
    push_pkt(0, 8'hD0, 1'b1);
    push_pkt(4, 8'hD8, 1'b0);
    chk(out_valid == 1'b1, "R3 full fifo presents data", int'(out_valid), 1);

    // R9 program bit does not clear the flag
    cfg_wr(2'd0, 8'h06);
    cfg_wr(2'd0, 8'h02);
    tick();
    chk(ovf_flag == 1'b1, "R9 flag survives program toggle", int'(ovf_flag), 1);

    // R7 restart while not empty keeps flag
    trace_en = 1'b1; tick();
    trace_en = 1'b0; tick();
    chk(ovf_flag == 1'b1, "R7 busy restart keeps flag", int'(ovf_flag), 1);
    drain();
    chk(fifo_warn == 1'b0, "R5 warn clears after drain", int'(fifo_warn), 0);
    trace_en = 1'b1; tick();
    chk(ovf_flag == 1'b0, "R7 restart when empty clears flag", int'(ovf_flag), 0);
    trace_en = 1'b0;

    // R8 power-down clears and holds flag clear
    out_ready = 1'b0;
    for (int p = 0; p < 8; p++) push_pkt(4, 8'h80 + 8'(p*4), 1'b1);
    push_pkt(2, 8'hE0, 1'b1);
    chk(ovf_flag == 1'b1, "R4 flag on second drop", int'(ovf_flag), 1);
    cfg_wr(2'd0, 8'h03);
    tick();
    chk(ovf_flag == 1'b0, "R8 power-down clears flag", int'(ovf_flag), 0);
    push_pkt(1, 8'hF0, 1'b1);
    tick();
    chk(ovf_flag == 1'b0, "R8 flag held clear in power-down", int'(ovf_flag), 0);
    cfg_wr(2'd0, 8'h02);
    drain();
    chk(sb.size() == 0, "R3 all stored bytes delivered", sb.size(), 0);

    finish_run();
  end

endmodule